// File: doc/BRIEF.md
# Output Bus Test Pattern Generator

This block sits in front of a converter's parallel output bus and can replace the live sample stream with known test words, so that the receiving logic can check the link for stuck, swapped or shorted bits. A mode field picks either normal pass-through or one of a set of fixed patterns: mid-scale, the two full-scale extremes, a checkerboard, a one/zero toggle, or two user-defined words. Every clock cycle is one output phase, and the output word is registered once.

The user words are loaded one byte at a time through write strobes that stand in for a serial configuration port. A separate user-mode field decides how the user words are presented: held static, alternated on every phase, or stepped through a single time and then frozen. Writing either mode field restarts the alternation so that the first word after a write is always the first word of the pattern.

Top module: `test_pattern_gen`

## Requirements
- R1: After reset the output is 0x0000, the mode is pass-through, the user mode is static and both user words read as 0x0000.
- R2: With mode code 0 the output equals the sample input of the previous cycle.
- R3: Mode code 1 outputs 0x8000, code 2 outputs 0xFFFF and code 3 outputs 0x0000 on every cycle.
- R4: Mode code 4 outputs 0xAAAA, then 0x5555, alternating on each cycle, whatever the user mode.
- R5: Mode code 7 outputs 0xFFFF, then 0x0000, alternating on each cycle.
- R6: Mode code 8 with user mode 00 (static) outputs user word 1 on every cycle.
- R7: Mode code 8 with user mode 01 (alternate) outputs word 1, word 2, word 1, ... on successive cycles.
- R8: Mode code 8 with user mode 10 (single once) outputs word 1 and holds it; with user mode 11 (alternate once) it outputs word 1 for one cycle, then word 2 held until a mode field is written.
- R9: Mode codes 5, 6 and 9 to 15 are reserved and behave as pass-through.
- R10: A write to the mode field or to the user-mode field, even with an unchanged value, restarts the pattern so the first output after the write is its first word.
- R11: A byte write with select 0 loads bits 7:0 of word 1, select 1 bits 15:8 of word 1, select 2 bits 7:0 of word 2 and select 3 bits 15:8 of word 2; all other bytes are left unchanged.
- R12: Any write or sample change is visible on the output exactly one cycle after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output phase clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_in | input | 16 | Converter sample word |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 4 | New mode code |
| umode_wr | input | 1 | Write strobe for the user-mode field |
| umode_wdata | input | 2 | New user mode: 00 static, 01 alternate, 10 single once, 11 alternate once |
| byte_wr | input | 1 | Write strobe for one user-word byte |
| byte_sel | input | 2 | Byte select: 0/1 word 1 low/high, 2/3 word 2 low/high |
| byte_data | input | 8 | Byte value to load |
| data_out | output | 16 | Registered output word |

## Verification
A wrong phase bit shows up as a checkerboard, toggle or alternating user pattern starting on its second word, or as two equal words in a row, on the second output after a mode write. A corrupted mode register turns into a wrong constant or leaks sample data on the very next cycle. A byte loaded into the wrong lane of a user word is seen on the first user-pattern output after the write, and the alternating user mode exposes the other word's lanes one cycle later.

// File: rtl/test_pattern_gen.sv
module test_pattern_gen #(
  parameter int DW = 16,
  parameter int MW = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DW-1:0]                 sample_in,
  input  logic                          mode_wr,
  input  logic [MW-1:0]                 mode_wdata,
  input  logic                          umode_wr,
  input  logic [1:0]                    umode_wdata,
  input  logic                          byte_wr,
  input  logic [$clog2(2*(DW/8))-1:0]   byte_sel,
  input  logic [7:0]                    byte_data,
  output logic [DW-1:0]                 data_out
);

  localparam int NB   = DW / 8;
  localparam int SELW = $clog2(2 * NB);

  localparam logic [MW-1:0] M_PASS = MW'(0);
  localparam logic [MW-1:0] M_MID  = MW'(1);
  localparam logic [MW-1:0] M_PFS  = MW'(2);
  localparam logic [MW-1:0] M_NFS  = MW'(3);
  localparam logic [MW-1:0] M_CHK  = MW'(4);
  localparam logic [MW-1:0] M_ONEZ = MW'(7);
  localparam logic [MW-1:0] M_USER = MW'(8);

  localparam logic [1:0] UM_STATIC = 2'b00;
  localparam logic [1:0] UM_ALT    = 2'b01;
  localparam logic [1:0] UM_ALT1   = 2'b11;

  localparam logic [DW-1:0] PAT_MID = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] PAT_CHK = {(DW/2){2'b10}};

  logic [MW-1:0] mode_q;
  logic [1:0]    um_q;
  logic          phase_q;
  logic [DW-1:0] w1_q, w2_q;
  logic [DW-1:0] nxt;
  logic          restart, alt_en, user_sel;

  assign restart  = mode_wr | umode_wr;
  assign user_sel = (mode_q == M_USER);
  assign alt_en   = (mode_q == M_CHK) || (mode_q == M_ONEZ) ||
                    (user_sel && um_q == UM_ALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_PASS;
      um_q   <= UM_STATIC;
    end else begin
      if (mode_wr)  mode_q <= mode_wdata;
      if (umode_wr) um_q   <= umode_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w1_q <= '0;
      w2_q <= '0;
    end else if (byte_wr) begin
      for (int b = 0; b < NB; b++) begin
        if (byte_sel == SELW'(b))      w1_q[b*8 +: 8] <= byte_data;
        if (byte_sel == SELW'(NB + b)) w2_q[b*8 +: 8] <= byte_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             phase_q <= 1'b0;
    else if (restart)                       phase_q <= 1'b0;
    else if (alt_en)                        phase_q <= ~phase_q;
    else if (user_sel && um_q == UM_ALT1)   phase_q <= 1'b1;
  end

  always_comb begin
    case (mode_q)
      M_MID:   nxt = PAT_MID;
      M_PFS:   nxt = '1;
      M_NFS:   nxt = '0;
      M_CHK:   nxt = phase_q ? ~PAT_CHK : PAT_CHK;
      M_ONEZ:  nxt = phase_q ? '0 : '1;
      M_USER:  nxt = phase_q ? w2_q : w1_q;
      default: nxt = sample_in;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_out <= '0;
    else        data_out <= nxt;
  end

  // R2 R9
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PASS || mode_q == MW'(5) || mode_q == MW'(6) || mode_q > M_USER)
      |=> (data_out == $past(sample_in)));

  // R3
  mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_MID) |=> (data_out == PAT_MID));

  // R3
  pfs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PFS) |=> (data_out == {DW{1'b1}}));

  // R3
  nfs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_NFS) |=> (data_out == {DW{1'b0}}));

  // R4 R5
  alt_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == M_CHK || mode_q == M_ONEZ) && $past(mode_q) == mode_q && !$past(restart))
      |=> (data_out == ~$past(data_out)));

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_wdata == M_CHK) |=> ##1 (data_out == PAT_CHK));

  // R11
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr && byte_sel == SELW'(0)) |=> (w1_q[7:0] == $past(byte_data)));

  // R8
  hold_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (user_sel && um_q == UM_ALT1 && phase_q && !restart) |=> phase_q);

endmodule

// File: tb/test_pattern_gen_tb.sv
module test_pattern_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] sample_in = '0;
  logic        mode_wr = 1'b0;
  logic [3:0]  mode_wdata = '0;
  logic        umode_wr = 1'b0;
  logic [1:0]  umode_wdata = '0;
  logic        byte_wr = 1'b0;
  logic [1:0]  byte_sel = '0;
  logic [7:0]  byte_data = '0;
  logic [15:0] data_out;

  int checks = 0;
  int errs = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  test_pattern_gen u_dut (
    .clk(clk), .rst_n(rst_n), .sample_in(sample_in),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .umode_wr(umode_wr), .umode_wdata(umode_wdata),
    .byte_wr(byte_wr), .byte_sel(byte_sel), .byte_data(byte_data),
    .data_out(data_out)
  );

  typedef struct packed {
    logic [3:0]  m;
    logic [1:0]  u;
    logic [15:0] s;
    logic [15:0] e0;
    logic [15:0] e1;
    logic [15:0] e2;
    logic [7:0]  r;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{4'd0,  2'd0, 16'h4321, 16'h4321, 16'h4321, 16'h4321, 8'd2},  // R2
    '{4'd1,  2'd0, 16'h0000, 16'h8000, 16'h8000, 16'h8000, 8'd3},  // R3
    '{4'd2,  2'd0, 16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF, 8'd3},  // R3
    '{4'd3,  2'd0, 16'h1111, 16'h0000, 16'h0000, 16'h0000, 8'd3},  // R3
    '{4'd4,  2'd0, 16'h0000, 16'hAAAA, 16'h5555, 16'hAAAA, 8'd4},  // R4
    '{4'd7,  2'd0, 16'h0000, 16'hFFFF, 16'h0000, 16'hFFFF, 8'd5},  // R5
    '{4'd8,  2'd0, 16'h0000, 16'h1234, 16'h1234, 16'h1234, 8'd6},  // R6
    '{4'd8,  2'd1, 16'h0000, 16'h1234, 16'hBEEF, 16'h1234, 8'd7},  // R7
    '{4'd8,  2'd2, 16'h0000, 16'h1234, 16'h1234, 16'h1234, 8'd8},  // R8
    '{4'd8,  2'd3, 16'h0000, 16'h1234, 16'hBEEF, 16'hBEEF, 8'd8},  // R8
    '{4'd5,  2'd0, 16'h0F0F, 16'h0F0F, 16'h0F0F, 16'h0F0F, 8'd9},  // R9
    '{4'd6,  2'd0, 16'h7001, 16'h7001, 16'h7001, 16'h7001, 8'd9},  // R9
    '{4'd9,  2'd0, 16'h00FF, 16'h00FF, 16'h00FF, 16'h00FF, 8'd9},  // R9
    '{4'd15, 2'd0, 16'hC3C3, 16'hC3C3, 16'hC3C3, 16'hC3C3, 8'd9},  // R9
    '{4'd4,  2'd1, 16'h0000, 16'hAAAA, 16'h5555, 16'hAAAA, 8'd4}   // R4
  };

  task automatic chk(input logic [15:0] exp, input int r);
    checks++;
    if (data_out !== exp) begin
      errs++;
      $display("FAIL R%0d: data_out=%h expected=%h", r, data_out, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge where the first new word is visible
  task automatic apply(input logic [3:0] m, input logic [1:0] u);
    mode_wr = 1'b1; mode_wdata = m; umode_wr = 1'b1; umode_wdata = u;
    @(negedge clk);
    mode_wr = 1'b0; umode_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic load_byte(input logic [1:0] sel, input logic [7:0] d);
    byte_wr = 1'b1; byte_sel = sel; byte_data = d;
    @(negedge clk);
    byte_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(16'h0000, 1);                 // R1 output after reset
    sample_in = 16'h9999;
    @(negedge clk);
    chk(16'h9999, 1);                 // R1 default mode is pass-through
    apply(4'd8, 2'd1);
    chk(16'h0000, 1);                 // R1 word 1 defaults to zero
    @(negedge clk);
    chk(16'h0000, 1);                 // R1 word 2 defaults to zero

    load_byte(2'd0, 8'h34);           // R11 lanes
    load_byte(2'd1, 8'h12);
    load_byte(2'd2, 8'hEF);
    load_byte(2'd3, 8'hBE);

    for (int i = 0; i < NV; i++) begin
      sample_in = TBL[i].s;
      apply(TBL[i].m, TBL[i].u);
      chk(TBL[i].e0, int'(TBL[i].r));
      @(negedge clk);
      chk(TBL[i].e1, int'(TBL[i].r));
      @(negedge clk);
      chk(TBL[i].e2, int'(TBL[i].r));
    end

    // R10 rewriting the same mode code restarts the checkerboard
    apply(4'd4, 2'd0);
    chk(16'hAAAA, 10);
    @(negedge clk);
    chk(16'h5555, 10);
    apply(4'd4, 2'd0);
    chk(16'hAAAA, 10);

    // R10 a user-mode write alone restarts alternation at word 1
    apply(4'd8, 2'd1);
    chk(16'h1234, 10);
    @(negedge clk);
    chk(16'hBEEF, 10);
    umode_wr = 1'b1; umode_wdata = 2'd1;
    @(negedge clk);
    umode_wr = 1'b0;
    @(negedge clk);
    chk(16'h1234, 10);

    // R8 alternate-once keeps word 2 indefinitely
    apply(4'd8, 2'd3);
    chk(16'h1234, 8);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(16'hBEEF, 8);
    end

    // R12 pass-through follows a changing sample one cycle later
    sample_in = 16'h0001;
    apply(4'd0, 2'd0);
    for (int k = 0; k < 4; k++) begin
      sample_in = 16'h0100 + 16'(k * 7);
      @(negedge clk);
      chk(16'h0100 + 16'(k * 7), 12);
    end

    // R11 single byte updates leave the other lanes alone
    apply(4'd8, 2'd0);
    chk(16'h1234, 11);
    load_byte(2'd1, 8'h56);
    @(negedge clk);
    chk(16'h5634, 11);
    load_byte(2'd2, 8'h01);
    apply(4'd8, 2'd1);
    chk(16'h5634, 11);
    @(negedge clk);
    chk(16'hBE01, 11);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

endmodule